// File: doc/BRIEF.md
# Periodic DRAM Refresh Controller

This block keeps dynamic memory on a shared system bus alive. A free-running interval timer marks the moment each refresh falls due, nominally every 15.6 µs with the period given in clocks. Every due refresh is added to a small saturating backlog counter. When the backlog is non-zero, the controller requests the bus. It starts a refresh only when all four start conditions hold: the bus is granted, the bus is idle, no peripheral is stretching the cycle with the ready line, and no external master holds the bus. A refresh lasts a fixed number of clocks. During it the active-low refresh strobe is low, the current refresh row is on the row output, and an inhibit line tells the bus cycle sequencer to keep its I/O read and write strobes inactive.

When refreshes are held off, they are not lost. The backlog is worked off with refreshes that follow each other as closely as the bus allows. If a refresh falls due while the backlog is already full, a sticky flag records that a refresh was lost. The row counter steps once per completed refresh and wraps at a configured row count.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset the strobe is high, the inhibit and request outputs are low, and the row, backlog and lost-refresh flag are all zero.
- R2: The backlog rises by one every PERIOD_CLKS clocks. The first rise is visible PERIOD_CLKS clocks after reset is released.
- R3: A refresh never starts in a cycle after one in which the ready input was low.
- R4: A refresh never starts in a cycle after one in which the active-low external-master input was low.
- R5: The bus request is high while waiting for a start and while a refresh runs. A refresh starts one clock after a cycle in which the request, grant and bus-idle were all high.
- R6: Once started, the refresh strobe stays low for exactly STROBE_CLKS consecutive clocks.
- R7: The I/O inhibit output is high in exactly the clocks in which the refresh strobe is low.
- R8: Each completed refresh lowers the backlog by one. A completion and a new due refresh in the same clock leave it unchanged. The backlog never exceeds MAX_PEND.
- R9: When a refresh falls due with the backlog at MAX_PEND and none completing, the lost-refresh flag goes high and stays high until reset.
- R10: The row output advances by one after every completed refresh and goes from ROWS-1 back to 0.
- R11: After each refresh the strobe is high for at least one clock. If backlog remains, the request rises again directly after that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idle_i | input | 1 | No bus cycle in progress |
| bus_gnt_i | input | 1 | Bus granted to the refresh controller |
| ready_i | input | 1 | Ready line; low while a peripheral stretches a cycle |
| ext_master_n_i | input | 1 | Low while an external master owns the bus |
| bus_req_o | output | 1 | Bus request for refresh |
| refresh_n_o | output | 1 | Refresh strobe, active low |
| io_inhibit_o | output | 1 | Keep I/O read/write strobes inactive |
| row_addr_o | output | ROW_W | Refresh row address |
| pending_o | output | PEND_W | Refresh backlog count |
| overflow_o | output | 1 | Sticky lost-refresh flag |

## Verification
The bench stalls the bus with ready low, then with an external master, then with idle low and with grant low, long enough for refreshes to pile up. When the stall ends it expects the backlog to drain in back-to-back refreshes. A design that ignored a stall input would start a strobe during the stall. A design that dropped a late request would drain too few refreshes. The bench also hits the clock where a completion and a new due refresh coincide, the row wrap from ROWS-1 to 0, and the due refresh that arrives on a full backlog. Wrong handling of these shows up as a backlog off by one, a row that skips 0 or overruns, or a lost-refresh flag that never rises or later clears.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
    typedef enum logic [1:0] {
        RF_IDLE = 2'd0,
        RF_REQ  = 2'd1,
        RF_RUN  = 2'd2,
        RF_GAP  = 2'd3
    } rf_state_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int PERIOD_CLKS = 1248,
    localparam int CNT_W = $clog2(PERIOD_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t q, d;

    assign tick_o = (q.cnt == CNT_W'(PERIOD_CLKS - 1));

    always_comb begin
        d = q;
        if (tick_o) d.cnt = '0;
        else        d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: the interval counter stays inside its period
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(PERIOD_CLKS));
endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
    parameter int MAX_PEND = 4,
    localparam int PEND_W = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              done_i,
    output logic [PEND_W-1:0] pending_o,
    output logic              overflow_o
);
    typedef struct packed {
        logic [PEND_W-1:0] cnt;
        logic              ovf;
    } bl_regs_t;

    bl_regs_t q, d;

    always_comb begin
        d = q;
        if (tick_i && !done_i) begin
            if (q.cnt == PEND_W'(MAX_PEND)) d.ovf = 1'b1;
            else                            d.cnt = q.cnt + 1'b1;
        end else if (done_i && !tick_i) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending_o  = q.cnt;
    assign overflow_o = q.ovf;

    // R8: a completion is only reported against a non-empty backlog
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (q.cnt != '0));
    // R8: backlog bounded
    a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= PEND_W'(MAX_PEND));
    // R9: lost-refresh flag is sticky
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.ovf |=> q.ovf);
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int ROWS = 512,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    output logic [ROW_W-1:0] row_o
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
    } row_regs_t;

    row_regs_t q, d;

    always_comb begin
        d = q;
        if (done_i) begin
            if (q.row == ROW_W'(ROWS - 1)) d.row = '0;
            else                          d.row = q.row + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign row_o = q.row;

    // R10: row stays inside the configured range
    a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        q.row < ROW_W'(ROWS));
    // R10: row only moves on a completed refresh
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(q.row));
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
    import refresh_pkg::*;
#(
    parameter int STROBE_CLKS = 4,
    localparam int RUN_W = $clog2(STROBE_CLKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nz_i,
    input  logic bus_idle_i,
    input  logic bus_gnt_i,
    input  logic ready_i,
    input  logic ext_master_n_i,
    output logic bus_req_o,
    output logic refresh_n_o,
    output logic io_inhibit_o,
    output logic done_o
);
    typedef struct packed {
        rf_state_e        st;
        logic [RUN_W-1:0] run;
    } seq_regs_t;

    seq_regs_t q, d;
    logic      start;

    assign start  = (q.st == RF_REQ) && bus_gnt_i && bus_idle_i && ready_i && ext_master_n_i;
    assign done_o = (q.st == RF_RUN) && (q.run == RUN_W'(STROBE_CLKS - 1));

    always_comb begin
        d = q;
        unique case (q.st)
            RF_IDLE: if (pend_nz_i) d.st = RF_REQ;
            RF_REQ: begin
                if (start) begin
                    d.st  = RF_RUN;
                    d.run = '0;
                end
            end
            RF_RUN: begin
                if (done_o) begin
                    d.st  = RF_GAP;
                    d.run = '0;
                end else begin
                    d.run = q.run + 1'b1;
                end
            end
            RF_GAP: d.st = pend_nz_i ? RF_REQ : RF_IDLE;
            default: d.st = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RF_IDLE, run: '0};
        else        q <= d;
    end

    assign bus_req_o    = (q.st == RF_REQ) || (q.st == RF_RUN);
    assign refresh_n_o  = (q.st != RF_RUN);
    assign io_inhibit_o = (q.st == RF_RUN);

    // R3: no start out of a stretched cycle
    a_r3_no_start_stretched: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_n_o) |-> $past(ready_i));
    // R4: no start while an external master owns the bus
    a_r4_no_start_ext_master: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_n_o) |-> $past(ext_master_n_i));
    // R5: start only from a granted idle bus
    a_r5_granted_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_n_o) |-> $past(bus_gnt_i && bus_idle_i && bus_req_o));
    // R6: strobe counter never exceeds its length
    a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.run < RUN_W'(STROBE_CLKS));
    // R11: at least one high clock after every refresh
    a_r11_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_n_o) |=> refresh_n_o);
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int PERIOD_CLKS = 1248,
    parameter int STROBE_CLKS = 4,
    parameter int ROWS        = 512,
    parameter int MAX_PEND    = 4,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int PEND_W = $clog2(MAX_PEND + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_idle_i,
    input  logic              bus_gnt_i,
    input  logic              ready_i,
    input  logic              ext_master_n_i,
    output logic              bus_req_o,
    output logic              refresh_n_o,
    output logic              io_inhibit_o,
    output logic [ROW_W-1:0]  row_addr_o,
    output logic [PEND_W-1:0] pending_o,
    output logic              overflow_o
);
    logic tick;
    logic done;

    refresh_interval_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    refresh_backlog #(.MAX_PEND(MAX_PEND)) u_backlog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .done_i     (done),
        .pending_o  (pending_o),
        .overflow_o (overflow_o)
    );

    refresh_sequencer #(.STROBE_CLKS(STROBE_CLKS)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .pend_nz_i      (pending_o != '0),
        .bus_idle_i     (bus_idle_i),
        .bus_gnt_i      (bus_gnt_i),
        .ready_i        (ready_i),
        .ext_master_n_i (ext_master_n_i),
        .bus_req_o      (bus_req_o),
        .refresh_n_o    (refresh_n_o),
        .io_inhibit_o   (io_inhibit_o),
        .done_o         (done)
    );

    refresh_row_ctr #(.ROWS(ROWS)) u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (done),
        .row_o  (row_addr_o)
    );

    // R7: inhibit tracks the strobe at the block boundary
    a_r7_inhibit_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        io_inhibit_o == !refresh_n_o);
endmodule

// File: tb/dram_refresh_ctrl_tb.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_tb;
    localparam int P  = 20;
    localparam int S  = 3;
    localparam int NR = 5;
    localparam int MP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       b_idle = 1'b0, b_gnt = 1'b0, b_rdy = 1'b0, b_mst = 1'b0;
    logic       bus_req, refresh_n, io_inh, ovf;
    logic [2:0] row;
    logic [2:0] pend;

    int vectors = 0;
    int fails   = 0;
    bit finished = 0;

    // bench-side expectation state
    int m_cnt, m_pend, m_row, m_run, m_st; // st: 0 idle 1 req 2 run 3 gap
    bit m_ovf;
    bit prev_rn;

    always #4 clk = ~clk;

    dram_refresh_ctrl #(.PERIOD_CLKS(P), .STROBE_CLKS(S), .ROWS(NR), .MAX_PEND(MAX_PEND_F())) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_idle_i(b_idle), .bus_gnt_i(b_gnt),
        .ready_i(b_rdy), .ext_master_n_i(b_mst), .bus_req_o(bus_req),
        .refresh_n_o(refresh_n), .io_inhibit_o(io_inh), .row_addr_o(row),
        .pending_o(pend), .overflow_o(ovf)
    );

    function automatic int MAX_PEND_F();
        return MP;
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R6", "refresh_n", int'(refresh_n), (m_st == 2) ? 0 : 1);
        chk("R7", "io_inhibit", int'(io_inh), (m_st == 2) ? 1 : 0);
        chk("R5", "bus_req", int'(bus_req), (m_st == 1 || m_st == 2) ? 1 : 0);
        chk("R10", "row", int'(row), m_row);
        chk("R8", "pending", int'(pend), m_pend);
        chk("R9", "overflow", int'(ovf), int'(m_ovf));
        // start gating, judged against the inputs sampled at the last edge
        if (prev_rn && !refresh_n) begin
            chk("R3", "ready before start", int'(b_rdy), 1);
            chk("R4", "ext master before start", int'(b_mst), 1);
            chk("R5", "grant&idle before start", int'(b_gnt && b_idle), 1);
        end
        prev_rn = refresh_n;
    endtask

    // advance the expectation by one clock using the inputs now driven
    task automatic step_model();
        bit tick, done, start;
        int nst;
        tick  = (m_cnt == P - 1);
        done  = (m_st == 2) && (m_run == S - 1);
        start = (m_st == 1) && b_gnt && b_idle && b_rdy && b_mst;
        nst = m_st;
        case (m_st)
            0: if (m_pend != 0) nst = 1;
            1: if (start) begin nst = 2; m_run = 0; end
            2: if (done) begin nst = 3; m_run = 0; end else m_run++;
            default: nst = (m_pend != 0) ? 1 : 0;
        endcase
        if (tick && !done) begin
            if (m_pend == MP) m_ovf = 1;
            else m_pend++;
        end else if (done && !tick) m_pend--;
        if (done) m_row = (m_row + 1) % NR;
        m_cnt = tick ? 0 : m_cnt + 1;
        m_st  = nst;
    endtask

    // mode: 0 open, 1 ready low, 2 external master, 3 bus busy, 4 no grant, 5 random
    task automatic run_phase(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare_all();
            b_idle = 1; b_gnt = 1; b_rdy = 1; b_mst = 1;
            case (mode)
                1: b_rdy = 0;
                2: b_mst = 0;
                3: b_idle = 0;
                4: b_gnt = 0;
                5: begin
                    b_idle = ($urandom % 6) != 0;
                    b_gnt  = ($urandom % 6) != 0;
                    b_rdy  = ($urandom % 5) != 0;
                    b_mst  = ($urandom % 7) != 0;
                end
                default: ;
            endcase
            step_model();
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "refresh_n", int'(refresh_n), 1);
        chk("R1", "io_inhibit", int'(io_inh), 0);
        chk("R1", "bus_req", int'(bus_req), 0);
        chk("R1", "row", int'(row), 0);
        chk("R1", "pending", int'(pend), 0);
        chk("R1", "overflow", int'(ovf), 0);
        m_cnt = 0; m_pend = 0; m_row = 0; m_run = 0; m_st = 0; m_ovf = 0;
        prev_rn = 1;
        b_idle = 1; b_gnt = 1; b_rdy = 1; b_mst = 1;
        step_model();
        // R2: first due refresh visible P clocks after release
        run_phase(P - 1, 0);
        @(negedge clk);
        chk("R2", "pending at first due", int'(pend), 1);
        compare_all();
        step_model();
        run_phase(200, 0);   // R10 wraps twice over ten refreshes
        run_phase(70, 1);    // R3 stall, backlog builds
        run_phase(60, 0);    // R11 back-to-back drain
        run_phase(70, 2);    // R4 stall
        run_phase(60, 0);
        run_phase(50, 3);
        run_phase(40, 0);
        run_phase(3000, 5);  // R8 coincident tick/done under mixed traffic
        run_phase(150, 4);   // R9 backlog saturates and flag rises
        run_phase(100, 0);
        chk("R9", "flag still set", int'(ovf), 1);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule